// File: doc/BRIEF.md
# I2C Master Transfer Status Tracker

This block produces the interrupt status word of an I2C master controller. It watches the commands that software issues: manual transfer, automatic transfer, sequence transfer and stop. It also watches the programmed transfer length, the fill levels of the transmit and receive FIFOs, and the count of bytes still to move in the current transfer. From these it raises completion, stop, illegal-parameter, transmit-low and time-out flags. The serial engine's progress arrives as single-cycle pulses: a byte moved, transfer finished, stop finished, and abnormal end with FIFO flush.

A built-in wait timer reloads from a programmable limit whenever progress is made. It counts down only while the controller is stalled. There are three stall cases:
- the bus is held after a manual transfer, waiting for the next command;
- the transmit FIFO is empty while bytes remain to be sent;
- the receive FIFO is full while bytes remain to be received.

The sticky flags clear on a status read or on any new command. A set event always wins over a clear in the same cycle. A masked OR of the status word drives a single interrupt line.

Top module: `xfer_status_tracker`

## Requirements
- R1: After reset the status word and the interrupt line are all zero.
- R2: Status bit 0 (transmit low) is high in the cycle after one in which a manual (`cmdKind`=0) or automatic (`cmdKind`=1) transmit transfer is active, `txLevel` is 3 or less and `bytesLeft` exceeds `txLevel`. It is not sticky. It drops one cycle after the condition ends, or one cycle after an `abortFlush` pulse, which also ends the transfer.
- R3: A `xferDone` pulse during an active manual transfer sets status bit 1 (done, no stop). The controller then holds the bus, awaiting the next command.
- R4: A `xferDone` pulse during an active automatic or sequence (`cmdKind`=2) transfer sets status bit 2 (done, stop sent).
- R5: A `stopDone` pulse while a stop command (`cmdKind`=3) is active sets status bit 3.
- R6: An automatic or sequence command issued with `xferLen` equal to 0 sets status bit 4 in the next cycle. No transfer starts, so a later `xferDone` sets neither bit 1 nor bit 2.
- R7: Status bit 5 (time-out) is set after `waitLimit`+1 consecutive stalled cycles. The stall is one of three cases: bus held after a manual transfer; transmit active with `txLevel`=0 and `bytesLeft`≠0; receive active with `rxLevel` equal to the FIFO depth and `bytesLeft`≠0. The transfer then ends.
- R8: A `byteDone` pulse or an accepted command reloads the wait timer, so a stall interrupted by progress restarts its full count.
- R9: Status bits 1 to 5 are sticky and clear when `statusRead` or `cmdValid` is high. A flag set in the same cycle as a clear stays set.
- R10: `irq` is high exactly when some status bit is high and its `irqMask` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | A new command is issued this cycle |
| cmdKind | input | 2 | 0 manual, 1 automatic, 2 sequence, 3 stop |
| cmdIsTx | input | 1 | 1 for a transmit transfer, 0 for a receive transfer |
| xferLen | input | LEN_W | Programmed transfer length |
| bytesLeft | input | LEN_W | Bytes still to move in the current transfer |
| txLevel | input | LVL_W | Transmit FIFO occupancy |
| rxLevel | input | LVL_W | Receive FIFO occupancy |
| byteDone | input | 1 | Engine moved one byte |
| xferDone | input | 1 | Engine finished all bytes of the transfer |
| stopDone | input | 1 | Engine finished the stop command |
| abortFlush | input | 1 | Transfer ended abnormally, transmit FIFO flushed |
| statusRead | input | 1 | Status word is being read |
| waitLimit | input | TMR_W | Wait timer reload value |
| irqMask | input | 6 | Per-bit interrupt enable |
| status | output | 6 | Status word, bits 0 to 5 as in R2 to R7 |
| irq | output | 1 | Masked OR of the status word |

## Verification
Two functions can fall in the same cycle: a sticky flag being set and that flag being cleared by a status read or a new command. The bench forces this collision directly. It pulses `xferDone` together with `statusRead`, and it lets a time-out expire while a read is in flight. It also keeps a 5 % read rate in the random phase, so that reads land on completion and time-out edges. A collision passes when the flag is high in the following cycle and drops only on a later read with no set.

// File: rtl/xfer_status_pkg.sv
package xfer_status_pkg;

  typedef enum logic [1:0] {
    KIND_MAN  = 2'd0,
    KIND_AUTO = 2'd1,
    KIND_SEQ  = 2'd2,
    KIND_STOP = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HOLD = 2'd2,
    ST_STOP = 2'd3
  } ctl_state_e;

  localparam int FLAG_NUM     = 6;
  localparam int BIT_TXLOW    = 0;
  localparam int BIT_DONENS   = 1;
  localparam int BIT_DONES    = 2;
  localparam int BIT_STOPDONE = 3;
  localparam int BIT_ILLEGAL  = 4;
  localparam int BIT_TIMEOUT  = 5;

  typedef struct packed {
    logic setDoneNoStop;
    logic setDoneStop;
    logic setStopDone;
    logic setIllegal;
    logic setTimeout;
    logic clearAll;
    logic txLowCond;
    logic stall;
    logic timerReload;
  } strobe_t;

endpackage

// File: rtl/xfer_status_ctrl.sv
module xfer_status_ctrl
  import xfer_status_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int LOW_MARK   = 3,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdKind,
  input  logic             cmdIsTx,
  input  logic [LEN_W-1:0] xferLen,
  input  logic [LEN_W-1:0] bytesLeft,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             byteDone,
  input  logic             xferDone,
  input  logic             stopDone,
  input  logic             abortFlush,
  input  logic             statusRead,
  input  logic             timerZero,
  output strobe_t          strb
);

  ctl_state_e stateQ, stateD;
  cmd_kind_e  kindQ, kindD;
  logic       isTxQ, isTxD;

  cmd_kind_e  cmdKindE;
  logic       lenZero;
  logic       illegalCmd;
  logic       txStarved;
  logic       rxClogged;
  logic       holdWait;
  logic       stallNow;
  logic       expire;
  logic       txLowNow;
  logic       leftOverLevel;

  assign cmdKindE   = cmd_kind_e'(cmdKind);
  assign lenZero    = (xferLen == '0);
  assign illegalCmd = cmdValid && lenZero &&
                      (cmdKindE == KIND_AUTO || cmdKindE == KIND_SEQ);

  assign leftOverLevel = (bytesLeft > LEN_W'(txLevel));
  assign txStarved  = (stateQ == ST_XFER) && isTxQ && (txLevel == '0) && (bytesLeft != '0);
  assign rxClogged  = (stateQ == ST_XFER) && !isTxQ &&
                      (rxLevel == LVL_W'(FIFO_DEPTH)) && (bytesLeft != '0);
  assign holdWait   = (stateQ == ST_HOLD);
  assign stallNow   = txStarved || rxClogged || holdWait;

  assign txLowNow = (stateQ == ST_XFER) && isTxQ && (kindQ != KIND_SEQ) &&
                    (txLevel <= LVL_W'(LOW_MARK)) && leftOverLevel && !abortFlush;

  // time-out only when nothing of higher priority happens this cycle
  always_comb begin
    expire = 1'b0;
    if (!cmdValid && stallNow && timerZero) begin
      unique case (stateQ)
        ST_XFER: expire = !abortFlush && !xferDone;
        ST_HOLD: expire = 1'b1;
        default: expire = 1'b0;
      endcase
    end
  end

  always_comb begin
    stateD = stateQ;
    kindD  = kindQ;
    isTxD  = isTxQ;
    strb   = '0;

    strb.clearAll    = cmdValid || statusRead;
    strb.txLowCond   = txLowNow;
    strb.stall       = stallNow;
    strb.timerReload = cmdValid || byteDone || !stallNow;

    if (cmdValid) begin
      if (illegalCmd) begin
        stateD          = ST_IDLE;
        strb.setIllegal = 1'b1;
      end else if (cmdKindE == KIND_STOP) begin
        stateD = ST_STOP;
      end else begin
        stateD = ST_XFER;
        kindD  = cmdKindE;
        isTxD  = cmdIsTx;
      end
    end else if (expire) begin
      stateD          = ST_IDLE;
      strb.setTimeout = 1'b1;
    end else begin
      unique case (stateQ)
        ST_XFER: begin
          if (abortFlush) begin
            stateD = ST_IDLE;
          end else if (xferDone) begin
            if (kindQ == KIND_MAN) begin
              stateD             = ST_HOLD;
              strb.setDoneNoStop = 1'b1;
            end else begin
              stateD           = ST_IDLE;
              strb.setDoneStop = 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (stopDone) begin
            stateD           = ST_IDLE;
            strb.setStopDone = 1'b1;
          end
        end
        default: stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      kindQ  <= KIND_MAN;
      isTxQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      kindQ  <= kindD;
      isTxQ  <= isTxD;
    end
  end

endmodule

// File: rtl/xfer_status_dp.sv
module xfer_status_dp
  import xfer_status_pkg::*;
#(
  parameter int TMR_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [TMR_W-1:0]    waitLimit,
  input  logic [FLAG_NUM-1:0] irqMask,
  output logic                timerZero,
  output logic [FLAG_NUM-1:0] status,
  output logic                irq
);

  localparam int STICKY_N = FLAG_NUM - 1;

  logic [TMR_W-1:0]    waitCntQ;
  logic                txLowQ;
  logic [STICKY_N-1:0] stickyQ;
  logic [STICKY_N-1:0] setVec;

  assign timerZero = (waitCntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCntQ <= '0;
    end else if (strb.timerReload) begin
      waitCntQ <= waitLimit;
    end else if (strb.stall && !timerZero) begin
      waitCntQ <= waitCntQ - 1'b1;
    end
  end

  assign setVec[BIT_DONENS-1]   = strb.setDoneNoStop;
  assign setVec[BIT_DONES-1]    = strb.setDoneStop;
  assign setVec[BIT_STOPDONE-1] = strb.setStopDone;
  assign setVec[BIT_ILLEGAL-1]  = strb.setIllegal;
  assign setVec[BIT_TIMEOUT-1]  = strb.setTimeout;

  for (genvar gi = 0; gi < STICKY_N; gi++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stickyQ[gi] <= 1'b0;
      end else if (setVec[gi]) begin
        stickyQ[gi] <= 1'b1;
      end else if (strb.clearAll) begin
        stickyQ[gi] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txLowQ <= 1'b0;
    else       txLowQ <= strb.txLowCond;
  end

  assign status = {stickyQ, txLowQ};
  assign irq    = |(status & irqMask);

endmodule

// File: rtl/xfer_status_tracker.sv
module xfer_status_tracker
  import xfer_status_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int LOW_MARK   = 3,
  parameter int TMR_W      = 12,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdKind,
  input  logic             cmdIsTx,
  input  logic [LEN_W-1:0] xferLen,
  input  logic [LEN_W-1:0] bytesLeft,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             byteDone,
  input  logic             xferDone,
  input  logic             stopDone,
  input  logic             abortFlush,
  input  logic             statusRead,
  input  logic [TMR_W-1:0] waitLimit,
  input  logic [5:0]       irqMask,
  output logic [5:0]       status,
  output logic             irq
);

  strobe_t strb;
  logic    timerZero;

  xfer_status_ctrl #(
    .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH), .LOW_MARK(LOW_MARK)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdIsTx(cmdIsTx),
    .xferLen(xferLen), .bytesLeft(bytesLeft),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .byteDone(byteDone), .xferDone(xferDone), .stopDone(stopDone),
    .abortFlush(abortFlush), .statusRead(statusRead),
    .timerZero(timerZero), .strb(strb)
  );

  xfer_status_dp #(.TMR_W(TMR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .waitLimit(waitLimit), .irqMask(irqMask),
    .timerZero(timerZero), .status(status), .irq(irq)
  );

endmodule

// File: rtl/xfer_status_chk.sv
module xfer_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdKind,
  input logic       xferZero,
  input logic       xferDone,
  input logic       stopDone,
  input logic       statusRead,
  input logic       stallSeen,
  input logic       anySet,
  input logic [3:0] txLevel,
  input logic [5:0] status,
  input logic       irq
);

  // R6
  illegal_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && xferZero && (cmdKind == 2'd1 || cmdKind == 2'd2))
      |=> (status[4] && !status[1] && !status[2]));

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !anySet) |=> (status[5:1] == 5'd0));

  // R3
  done_nostop_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> $past(xferDone));

  // R4
  done_stop_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[2]) |-> $past(xferDone));

  // R5
  stop_done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[3]) |-> $past(stopDone));

  // R7
  timeout_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[5]) |-> $past(stallSeen));

  // R2
  tx_low_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[0] |-> ($past(txLevel) <= 4'd3));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == 6'd0) |-> !irq);

endmodule

bind xfer_status_tracker xfer_status_chk i_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
  .xferZero(xferLen == '0), .xferDone(xferDone), .stopDone(stopDone),
  .statusRead(statusRead), .stallSeen(strb.stall),
  .anySet(strb.setDoneNoStop | strb.setDoneStop | strb.setStopDone |
          strb.setIllegal | strb.setTimeout),
  .txLevel(4'(txLevel)), .status(status), .irq(irq)
);

// File: tb/test_xfer_status_tracker.sv
module test_xfer_status_tracker;

  localparam int LEN_W = 8;
  localparam int DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int TMR_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 0, cmdIsTx = 0, byteDone = 0, xferDone = 0;
  logic stopDone = 0, abortFlush = 0, statusRead = 0;
  logic [1:0] cmdKind = 0;
  logic [LEN_W-1:0] xferLen = 0, bytesLeft = 0;
  logic [LVL_W-1:0] txLevel = 0, rxLevel = 0;
  logic [TMR_W-1:0] waitLimit = 4;
  logic [5:0] irqMask = 6'h3f;
  logic [5:0] status;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xfer_status_tracker #(.LEN_W(LEN_W), .FIFO_DEPTH(DEPTH), .TMR_W(TMR_W))
  i_xfer_status_tracker (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdIsTx(cmdIsTx), .xferLen(xferLen), .bytesLeft(bytesLeft),
    .txLevel(txLevel), .rxLevel(rxLevel), .byteDone(byteDone),
    .xferDone(xferDone), .stopDone(stopDone), .abortFlush(abortFlush),
    .statusRead(statusRead), .waitLimit(waitLimit), .irqMask(irqMask),
    .status(status), .irq(irq)
  );

  // reference model built from the requirements
  int mSt = 0;    // 0 idle, 1 transfer, 2 hold, 3 stop
  int mKind = 0;
  bit mTx = 0;
  int mCnt = 0;
  logic [5:0] mStat = 0;

  function automatic bit stalled(int st, bit tx);
    if (st == 2) return 1;
    if (st == 1 && tx && txLevel == 0 && bytesLeft != 0) return 1;
    if (st == 1 && !tx && rxLevel == DEPTH && bytesLeft != 0) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      bit stl, low;
      logic [5:1] setV;
      int nSt;
      stl = stalled(mSt, mTx);
      low = (mSt == 1) && mTx && (mKind != 2) && (txLevel <= 3) &&
            (bytesLeft > txLevel) && !abortFlush;
      setV = 0;
      nSt = mSt;
      if (cmdValid) begin
        if ((cmdKind == 1 || cmdKind == 2) && xferLen == 0) begin
          setV[4] = 1; nSt = 0;
        end else if (cmdKind == 3) nSt = 3;
        else begin nSt = 1; mKind = cmdKind; mTx = cmdIsTx; end
      end else if (mSt == 1 && abortFlush) nSt = 0;
      else if (mSt == 1 && xferDone) begin
        if (mKind == 0) begin setV[1] = 1; nSt = 2; end
        else begin setV[2] = 1; nSt = 0; end
      end else if (stl && mCnt == 0) begin setV[5] = 1; nSt = 0; end
      else if (mSt == 3 && stopDone) begin setV[3] = 1; nSt = 0; end
      for (int b = 1; b < 6; b++)
        mStat[b] = setV[b] | (mStat[b] & !(cmdValid | statusRead));
      mStat[0] = low;
      if (cmdValid || byteDone || !stl) mCnt = waitLimit;
      else if (mCnt != 0) mCnt = mCnt - 1;
      mSt = nSt;
    end
  end

  function automatic string reqOf(int b);
    case (b)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3: return "R5"; 4: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareModel();
    for (int b = 0; b < 6; b++)
      chk(status[b] === mStat[b], (b > 0) ? {reqOf(b), "/R9"} : reqOf(b),
          status[b], mStat[b]);
    chk(irq === |(mStat & irqMask), "R10", irq, |(mStat & irqMask));
  endtask

  task automatic quiet();
    cmdValid = 0; byteDone = 0; xferDone = 0; stopDone = 0;
    abortFlush = 0; statusRead = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compareModel();
    quiet();
  endtask

  task automatic issue(int kind, bit tx, int len);
    cmdValid = 1; cmdKind = 2'(kind); cmdIsTx = tx; xferLen = LEN_W'(len);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status === 6'd0, "R1", status, 0);
    chk(irq === 1'b0, "R1", irq, 0);
    rstN = 1;
    @(negedge clk);

    // R6 illegal automatic command, then an engine done pulse is ignored
    issue(1, 1, 0); step();
    chk(status[4] === 1'b1, "R6", status[4], 1);
    xferDone = 1; step();
    chk(status[2:1] === 2'b00, "R6", status[2:1], 0);
    statusRead = 1; step();
    chk(status === 6'd0, "R9", status, 0);

    // R2 transmit low, then abort drops it
    txLevel = 2; bytesLeft = 5; rxLevel = 0;
    issue(0, 1, 5); step();
    step();
    chk(status[0] === 1'b1, "R2", status[0], 1);
    abortFlush = 1; step();
    chk(status[0] === 1'b0, "R2", status[0], 0);

    // R7 and R8: starved transmit, limit 4 -> flag after 5 stalled edges
    waitLimit = 4; txLevel = 0; bytesLeft = 5;
    issue(0, 1, 5); step();
    step(); step();
    byteDone = 1; step();            // R8 reload
    repeat (4) step();
    chk(status[5] === 1'b0, "R8", status[5], 0);
    step();
    chk(status[5] === 1'b1, "R7", status[5], 1);

    // R9 collision: done and read in the same cycle, set wins
    txLevel = 4; bytesLeft = 1;
    issue(0, 1, 3); step();
    xferDone = 1; statusRead = 1; step();
    chk(status[1] === 1'b1, "R9", status[1], 1);
    statusRead = 1; step();
    chk(status[1] === 1'b0, "R9", status[1], 0);

    // R5 stop and R4 sequence completion
    issue(3, 0, 1); step();
    stopDone = 1; step();
    chk(status[3] === 1'b1, "R5", status[3], 1);
    issue(2, 0, 2); step();
    xferDone = 1; step();
    chk(status[2] === 1'b1, "R4", status[2], 1);

    // random phase
    void'($urandom(32'h5eed));
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(9) == 0) txLevel = LVL_W'($urandom_range(DEPTH));
      if ($urandom_range(9) == 0) rxLevel = LVL_W'($urandom_range(DEPTH));
      if ($urandom_range(9) == 0) bytesLeft = LEN_W'($urandom_range(6));
      if ($urandom_range(49) == 0) waitLimit = TMR_W'($urandom_range(8));
      if ($urandom_range(99) == 0) irqMask = 6'($urandom);
      if ($urandom_range(39) == 0)
        issue($urandom_range(3), 1'($urandom), $urandom_range(3));
      byteDone   = ($urandom_range(9) == 0);
      xferDone   = ($urandom_range(24) == 0);
      stopDone   = ($urandom_range(7) == 0);
      abortFlush = ($urandom_range(59) == 0);
      statusRead = ($urandom_range(19) == 0);
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule